// File: doc/BRIEF.md
# Interrupt Vector Ring Writer

This block takes fixed-size interrupt vectors from a producer and stores them in a circular buffer in a local dword memory. Each vector is eight 32-bit dwords, or 32 bytes. The block writes a vector one dword per cycle. It keeps a byte-granular write pointer and read pointer into the ring. It raises an interrupt line while enabled entries are waiting. Software consumes entries by reading the memory port, and then moves the read pointer forward, either through a register write or through a doorbell write.

A control register sets the ring size, the policy for a full ring, and writeback. Under the overwrite policy, a vector that arrives when the ring is full is still stored, and a sticky overflow flag is set in bit 0 of the write-pointer word. Under the drain policy, the producer is held off until software frees space, so no entry is lost. When writeback is enabled, every change of the write-pointer word is copied to a writeback register and marked with a one-cycle pulse.

The vector input uses valid/ready. A transfer happens on a rising clock edge where both `vec_valid` and `vec_ready` are high. The producer must hold `vec_valid` and `vec_data` stable until that edge. After a transfer, `vec_ready` stays low while the eight dwords are written. Configuration, doorbell, memory-read and status pins are plain signals.

Top module: `ivr_ring_writer`

## Requirements
- R1: After reset, `vec_ready`, `irq` and `wb_pulse` are 0, and `ctrl_out`, `wptr_word`, `rptr_out` and `wb_word` are all 0.
- R2: A write to register 0 (`cfg_wr_addr`=0) loads the control fields:
  - bit 0 enables the ring;
  - bit 1 enables the interrupt;
  - bits 6:2 hold the ring size as log2 of the size in dwords, clamped to the range 4 to MEM_AW;
  - bit 7 enables the overflow flag;
  - bit 8 is the overflow-clear strobe, which reads back as 0;
  - bit 9 selects the drain policy;
  - bit 10 enables writeback.
  `ctrl_out` shows the stored fields at the same positions.
- R3: `vec_ready` is high only when the ring is enabled, no vector is being written, and the drain policy is not holding off a full ring. After a transfer, `vec_ready` stays low for the eight write cycles.
- R4: Dword k of an accepted vector (`vec_data` bits 32k+31:32k) is written to dword index (W/4 + k) modulo the ring size in dwords, where W is the byte write pointer. Eight cycles after the transfer edge, the write pointer becomes (W + 32) masked by (ring bytes − 1).
- R5: The ring is full when (W + 32) masked by (ring bytes − 1) equals the read pointer.
- R6: If the ring is full when a vector is accepted, the vector is still written and the write pointer still advances. Bit 0 of `wptr_word` is set only when the overflow-enable field is 1 and the drain policy is off; otherwise the overwrite is silent.
- R7: With the drain policy on, a full ring holds `vec_ready` low and the write pointer unchanged until the read pointer moves. The overflow flag never sets under this policy.
- R8: The overflow flag stays set until a control write with bit 8 set clears it. The write-pointer value is unchanged by the clear.
- R9: The read pointer is set by a write to register 1 or by a doorbell write. The value is masked to the ring and aligned to 32 bytes. A doorbell wins over a register write in the same cycle.
- R10: `irq` is high exactly when the ring enable and the interrupt enable are both set and the write pointer differs from the read pointer.
- R11: When writeback is enabled, each change of `wptr_word` is copied to `wb_word` with a one-cycle `wb_pulse`. When writeback is disabled, `wb_word` holds its value.
- R12: A control write with bit 0 clear also clears the interrupt enable. It resets the write pointer, the overflow flag and the read pointer to 0, and aborts any vector still being written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 1 | 0 = control, 1 = read pointer |
| cfg_wr_data | input | REG_W | Register write data |
| db_valid | input | 1 | Doorbell write strobe |
| db_data | input | PTR_W | Doorbell read-pointer value |
| vec_valid | input | 1 | Vector offered |
| vec_ready | output | 1 | Vector can be accepted |
| vec_data | input | 256 | Vector, dword 0 in the low bits |
| mem_rd_addr | input | MEM_AW | Memory read dword index |
| mem_rd_data | output | 32 | Memory read data |
| ctrl_out | output | REG_W | Stored control fields |
| wptr_word | output | PTR_W | Write pointer with overflow flag in bit 0 |
| rptr_out | output | PTR_W | Read pointer |
| wb_word | output | PTR_W | Writeback copy of the write-pointer word |
| wb_pulse | output | 1 | Writeback update marker |
| irq | output | 1 | Entries pending interrupt |

## Verification
The hardest state to reach is a ring that is already full at the moment a vector is accepted. That vector must set the flag, and a later vector must then overwrite the oldest entry while the flag stays set. The stimulus reaches it by choosing the smallest ring, which holds two vectors, leaving the read pointer at 0, and pushing three vectors back to back. The drain path is reached in the same way: a ring is filled, a valid vector is held against the stall, and then a doorbell frees one slot.

// File: rtl/ivr_pkg.sv
package ivr_pkg;
  localparam int DW_BITS    = 32;
  localparam int VEC_DWORDS = 8;
  localparam int VEC_W      = DW_BITS * VEC_DWORDS;
  localparam int VEC_BYTES  = VEC_DWORDS * 4;
  localparam int MIN_LOG2   = 4;
  localparam int CTRL_W     = 11;
  // control field positions
  localparam int C_ON    = 0;
  localparam int C_IRQ   = 1;
  localparam int C_SZ_LO = 2;
  localparam int C_SZ_HI = 6;
  localparam int C_OVF   = 7;
  localparam int C_CLR   = 8;
  localparam int C_DRAIN = 9;
  localparam int C_WB    = 10;
  localparam logic ADDR_CTRL = 1'b0;
  localparam logic ADDR_RPTR = 1'b1;
endpackage

// File: rtl/ivr_cfg_regs.sv
module ivr_cfg_regs
  import ivr_pkg::*;
#(
  parameter int MEM_AW = 8,
  parameter int REG_W  = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [REG_W-1:0] wr_data,
  output logic             ring_on,
  output logic             irq_en,
  output logic [4:0]       size_log2,
  output logic             ovf_en,
  output logic             drain,
  output logic             wb_en,
  output logic             disable_p,
  output logic             ovf_clr_p,
  output logic             rptr_wr_p,
  output logic [REG_W-1:0] ctrl_word
);
  logic ctrl_wr;

  function automatic logic [4:0] clamp_sz(input logic [4:0] s);
    if (s < 5'(MIN_LOG2)) return 5'(MIN_LOG2);
    if (s > 5'(MEM_AW))   return 5'(MEM_AW);
    return s;
  endfunction

  assign ctrl_wr   = wr_en && (wr_addr == ADDR_CTRL);
  assign disable_p = ctrl_wr && !wr_data[C_ON];
  assign ovf_clr_p = ctrl_wr && wr_data[C_CLR];
  assign rptr_wr_p = wr_en && (wr_addr == ADDR_RPTR);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ring_on   <= 1'b0;
      irq_en    <= 1'b0;
      size_log2 <= '0;
      ovf_en    <= 1'b0;
      drain     <= 1'b0;
      wb_en     <= 1'b0;
    end else if (ctrl_wr) begin
      ring_on   <= wr_data[C_ON];
      irq_en    <= wr_data[C_ON] & wr_data[C_IRQ];
      size_log2 <= clamp_sz(wr_data[C_SZ_HI:C_SZ_LO]);
      ovf_en    <= wr_data[C_OVF];
      drain     <= wr_data[C_DRAIN];
      wb_en     <= wr_data[C_WB];
    end
  end

  always_comb begin
    ctrl_word                  = '0;
    ctrl_word[C_ON]            = ring_on;
    ctrl_word[C_IRQ]           = irq_en;
    ctrl_word[C_SZ_HI:C_SZ_LO] = size_log2;
    ctrl_word[C_OVF]           = ovf_en;
    ctrl_word[C_DRAIN]         = drain;
    ctrl_word[C_WB]            = wb_en;
  end
endmodule

// File: rtl/ivr_ptr_track.sv
module ivr_ptr_track
  import ivr_pkg::*;
#(
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [4:0]       size_log2,
  input  logic             wb_en,
  input  logic             disable_p,
  input  logic             ovf_clr_p,
  input  logic             rptr_wr_p,
  input  logic [PTR_W-1:0] rptr_wr_data,
  input  logic             db_valid,
  input  logic [PTR_W-1:0] db_data,
  input  logic             commit,
  input  logic             commit_ovf,
  output logic [PTR_W-1:0] mask,
  output logic [PTR_W-1:0] wptr,
  output logic [PTR_W-1:0] rptr,
  output logic             ovf,
  output logic             full,
  output logic [PTR_W-1:0] wb_word,
  output logic             wb_pulse
);
  logic [PTR_W-1:0] align, w_n, r_n, word_q, word_n, w_adv;
  logic             o_n;

  assign mask   = (PTR_W'(1) << (int'(size_log2) + 2)) - PTR_W'(1);
  assign align  = mask & ~PTR_W'(VEC_BYTES - 1);
  assign w_adv  = (wptr + PTR_W'(VEC_BYTES)) & mask;
  assign full   = (w_adv == rptr);
  assign word_q = wptr | PTR_W'(ovf);

  always_comb begin
    w_n = wptr;
    r_n = rptr;
    o_n = ovf;
    if (commit) begin
      w_n = w_adv;
      if (commit_ovf) o_n = 1'b1;
    end
    if (ovf_clr_p && !(commit && commit_ovf)) o_n = 1'b0;
    if (db_valid)       r_n = db_data & align;
    else if (rptr_wr_p) r_n = rptr_wr_data & align;
    if (disable_p) begin
      w_n = '0;
      r_n = '0;
      o_n = 1'b0;
    end
    word_n = w_n | PTR_W'(o_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr     <= '0;
      rptr     <= '0;
      ovf      <= 1'b0;
      wb_word  <= '0;
      wb_pulse <= 1'b0;
    end else begin
      wptr     <= w_n;
      rptr     <= r_n;
      ovf      <= o_n;
      wb_pulse <= wb_en && (word_n != word_q);
      if (wb_en && (word_n != word_q)) wb_word <= word_n;
    end
  end
endmodule

// File: rtl/ivr_vec_writer.sv
module ivr_vec_writer
  import ivr_pkg::*;
#(
  parameter int MEM_AW = 8,
  parameter int PTR_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_on,
  input  logic              ovf_en,
  input  logic              drain,
  input  logic              abort,
  input  logic              full,
  input  logic [PTR_W-1:0]  wptr,
  input  logic [PTR_W-1:0]  mask,
  input  logic              vec_valid,
  input  logic [VEC_W-1:0]  vec_data,
  output logic              vec_ready,
  output logic              mem_we,
  output logic [MEM_AW-1:0] mem_waddr,
  output logic [DW_BITS-1:0] mem_wdata,
  output logic              commit,
  output logic              commit_ovf
);
  logic             busy, ovf_q;
  logic [2:0]       beat;
  logic [VEC_W-1:0] vec_q;
  logic [PTR_W-1:0] dw_mask;

  assign vec_ready  = ring_on && !busy && !(drain && full);
  assign dw_mask    = mask >> 2;
  assign mem_we     = busy;
  assign mem_waddr  = MEM_AW'(((wptr >> 2) + PTR_W'(beat)) & dw_mask);
  assign mem_wdata  = vec_q[int'(beat)*DW_BITS +: DW_BITS];
  assign commit     = busy && (beat == 3'(VEC_DWORDS - 1));
  assign commit_ovf = ovf_q;

  always_ff @(posedge clk) begin
    if (!rst_n || abort) begin
      busy  <= 1'b0;
      beat  <= '0;
      ovf_q <= 1'b0;
      vec_q <= '0;
    end else if (vec_valid && vec_ready) begin
      busy  <= 1'b1;
      beat  <= '0;
      vec_q <= vec_data;
      ovf_q <= full && ovf_en && !drain;
    end else if (busy) begin
      beat <= beat + 3'd1;
      if (commit) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/ivr_ring_mem.sv
module ivr_ring_mem
  import ivr_pkg::*;
#(
  parameter int MEM_AW = 8
) (
  input  logic               clk,
  input  logic               we,
  input  logic [MEM_AW-1:0]  waddr,
  input  logic [DW_BITS-1:0] wdata,
  input  logic [MEM_AW-1:0]  raddr,
  output logic [DW_BITS-1:0] rdata
);
  localparam int DEPTH = 1 << MEM_AW;
  logic [DW_BITS-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];
endmodule

// File: rtl/ivr_ring_writer.sv
module ivr_ring_writer
  import ivr_pkg::*;
#(
  parameter  int MEM_AW = 8,
  localparam int PTR_W  = MEM_AW + 2,
  localparam int REG_W  = (PTR_W > CTRL_W) ? PTR_W : CTRL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic               cfg_wr_addr,
  input  logic [REG_W-1:0]   cfg_wr_data,
  input  logic               db_valid,
  input  logic [PTR_W-1:0]   db_data,
  input  logic               vec_valid,
  output logic               vec_ready,
  input  logic [VEC_W-1:0]   vec_data,
  input  logic [MEM_AW-1:0]  mem_rd_addr,
  output logic [DW_BITS-1:0] mem_rd_data,
  output logic [REG_W-1:0]   ctrl_out,
  output logic [PTR_W-1:0]   wptr_word,
  output logic [PTR_W-1:0]   rptr_out,
  output logic [PTR_W-1:0]   wb_word,
  output logic               wb_pulse,
  output logic               irq
);
  logic              ring_on, irq_en, ovf_en, drain, wb_en;
  logic [4:0]        size_log2;
  logic              disable_p, ovf_clr_p, rptr_wr_p;
  logic [PTR_W-1:0]  mask, wptr, rptr;
  logic              ovf, full, commit, commit_ovf;
  logic              mem_we;
  logic [MEM_AW-1:0] mem_waddr;
  logic [DW_BITS-1:0] mem_wdata;

  ivr_cfg_regs #(.MEM_AW(MEM_AW), .REG_W(REG_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_wr_addr),
    .wr_data(cfg_wr_data), .ring_on(ring_on), .irq_en(irq_en),
    .size_log2(size_log2), .ovf_en(ovf_en), .drain(drain), .wb_en(wb_en),
    .disable_p(disable_p), .ovf_clr_p(ovf_clr_p), .rptr_wr_p(rptr_wr_p),
    .ctrl_word(ctrl_out)
  );

  ivr_ptr_track #(.PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .size_log2(size_log2), .wb_en(wb_en),
    .disable_p(disable_p), .ovf_clr_p(ovf_clr_p), .rptr_wr_p(rptr_wr_p),
    .rptr_wr_data(cfg_wr_data[PTR_W-1:0]), .db_valid(db_valid),
    .db_data(db_data), .commit(commit), .commit_ovf(commit_ovf),
    .mask(mask), .wptr(wptr), .rptr(rptr), .ovf(ovf), .full(full),
    .wb_word(wb_word), .wb_pulse(wb_pulse)
  );

  ivr_vec_writer #(.MEM_AW(MEM_AW), .PTR_W(PTR_W)) u_wr (
    .clk(clk), .rst_n(rst_n), .ring_on(ring_on), .ovf_en(ovf_en),
    .drain(drain), .abort(disable_p), .full(full), .wptr(wptr), .mask(mask),
    .vec_valid(vec_valid), .vec_data(vec_data), .vec_ready(vec_ready),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .commit(commit), .commit_ovf(commit_ovf)
  );

  ivr_ring_mem #(.MEM_AW(MEM_AW)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_rd_addr), .rdata(mem_rd_data)
  );

  assign wptr_word = wptr | PTR_W'(ovf);
  assign rptr_out  = rptr;
  assign irq       = ring_on && irq_en && (wptr != rptr);
endmodule

// File: rtl/ivr_ring_writer_chk.sv
module ivr_ring_writer_chk #(
  parameter int PTR_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic             cfg_wr_addr,
  input logic             wr_on,
  input logic             wr_clr,
  input logic             vec_valid,
  input logic             vec_ready,
  input logic             ring_on,
  input logic             irq_en,
  input logic             ovf_en,
  input logic             drain,
  input logic [PTR_W-1:0] wptr_word,
  input logic [PTR_W-1:0] rptr_out,
  input logic [PTR_W-1:0] wb_word,
  input logic             wb_pulse,
  input logic             irq
);
  a_r3_ready_needs_on: assert property (@(posedge clk) disable iff (!rst_n)
    vec_ready |-> ring_on);
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid && vec_ready |=> !vec_ready);
  a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_word[4:1] == 4'd0 && rptr_out[4:0] == 5'd0);
  a_r6_flag_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wptr_word[0]) |-> $past(ovf_en) && !$past(drain));
  a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_word[0] && !(cfg_wr_en && !cfg_wr_addr && (wr_clr || !wr_on))
    |=> wptr_word[0]);
  a_r10_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ring_on && irq_en && (wptr_word[PTR_W-1:5] != rptr_out[PTR_W-1:5]));
  a_r11_wb_matches: assert property (@(posedge clk) disable iff (!rst_n)
    wb_pulse |-> wb_word == wptr_word);
  a_r12_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en && !cfg_wr_addr && !wr_on
    |=> wptr_word == '0 && rptr_out == '0 && !ring_on && !irq_en);
endmodule

bind ivr_ring_writer ivr_ring_writer_chk #(.PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
  .wr_on(cfg_wr_data[0]), .wr_clr(cfg_wr_data[8]), .vec_valid(vec_valid),
  .vec_ready(vec_ready), .ring_on(ctrl_out[0]), .irq_en(ctrl_out[1]),
  .ovf_en(ctrl_out[7]), .drain(ctrl_out[9]), .wptr_word(wptr_word),
  .rptr_out(rptr_out), .wb_word(wb_word), .wb_pulse(wb_pulse), .irq(irq)
);

// File: tb/ivr_ring_writer_tb.sv
module ivr_ring_writer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MEM_AW = 8;
  localparam int PTR_W  = MEM_AW + 2;
  localparam int REG_W  = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr_en = 1'b0;
  logic cfg_wr_addr = 1'b0;
  logic [REG_W-1:0] cfg_wr_data = '0;
  logic db_valid = 1'b0;
  logic [PTR_W-1:0] db_data = '0;
  logic vec_valid = 1'b0;
  logic vec_ready;
  logic [255:0] vec_data = '0;
  logic [MEM_AW-1:0] mem_rd_addr = '0;
  logic [31:0] mem_rd_data;
  logic [REG_W-1:0] ctrl_out;
  logic [PTR_W-1:0] wptr_word, rptr_out, wb_word;
  logic wb_pulse, irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ivr_ring_writer #(.MEM_AW(MEM_AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .db_valid(db_valid), .db_data(db_data),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_data(vec_data),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .ctrl_out(ctrl_out),
    .wptr_word(wptr_word), .rptr_out(rptr_out), .wb_word(wb_word),
    .wb_pulse(wb_pulse), .irq(irq)
  );

  function automatic logic [31:0] pat(input int tag, input int k);
    return 32'hC0DE_0000 | 32'(tag << 8) | 32'(k);
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic addr, input logic [REG_W-1:0] data);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = addr; cfg_wr_data = data;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic ring(input logic [PTR_W-1:0] v);
    @(negedge clk);
    db_valid = 1'b1; db_data = v;
    @(negedge clk);
    db_valid = 1'b0;
  endtask

  task automatic push(input int tag);
    int waited = 0;
    @(negedge clk);
    for (int k = 0; k < 8; k++) vec_data[k*32 +: 32] = pat(tag, k);
    vec_valid = 1'b1;
    while (!vec_ready && waited < 50) begin
      @(negedge clk);
      waited++;
    end
    if (!vec_ready) chk("R3", "ready timeout", 32'(vec_ready), 32'd1);
    @(negedge clk);
    vec_valid = 1'b0;
    chk("R3", "ready low while writing", 32'(vec_ready), 32'd0);
    repeat (8) @(negedge clk);
  endtask

  task automatic mem_at(input string req, input int idx, input logic [31:0] exp);
    mem_rd_addr = MEM_AW'(idx);
    #1;
    chk(req, $sformatf("mem[%0d]", idx), mem_rd_data, exp);
  endtask

  task automatic t_reset;
    chk("R1", "vec_ready", 32'(vec_ready), 0);
    chk("R1", "irq", 32'(irq), 0);
    chk("R1", "wptr_word", 32'(wptr_word), 0);
    chk("R1", "rptr_out", 32'(rptr_out), 0);
    chk("R1", "ctrl_out", 32'(ctrl_out), 0);
    chk("R1", "wb_word", 32'(wb_word), 0);
  endtask

  task automatic t_ctrl_fields;
    cfg_write(1'b0, 11'h009);                 // size 2 -> clamped to 4
    chk("R2", "size clamp low", 32'(ctrl_out), 32'h011);
    cfg_write(1'b0, 11'h07D);                 // size 31 -> clamped to MEM_AW
    chk("R2", "size clamp high", 32'(ctrl_out), 32'h021);
    cfg_write(1'b0, 11'h000);
  endtask

  task automatic t_basic;
    cfg_write(1'b0, 11'h417);                 // on, irq, size 5, writeback
    chk("R3", "ready when idle", 32'(vec_ready), 1);
    chk("R10", "irq empty", 32'(irq), 0);
    push(1);
    for (int k = 0; k < 8; k++) mem_at("R4", k, pat(1, k));
    chk("R4", "wptr advance", 32'(wptr_word), 32);
    chk("R10", "irq pending", 32'(irq), 1);
    chk("R11", "writeback copy", 32'(wb_word), 32);
    cfg_write(1'b1, 11'd32);
    chk("R10", "irq after catch-up", 32'(irq), 0);
    cfg_write(1'b1, 11'h03F);
    chk("R9", "rptr mask/align", 32'(rptr_out), 32);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_addr = 1'b1; cfg_wr_data = 11'd0;
    db_valid = 1'b1; db_data = PTR_W'(64);
    @(negedge clk);
    cfg_wr_en = 1'b0; db_valid = 1'b0;
    chk("R9", "doorbell priority", 32'(rptr_out), 64);
  endtask

  task automatic t_drain;
    cfg_write(1'b0, 11'h000);
    cfg_write(1'b0, 11'h217);                 // on, irq, size 5, drain
    push(1); push(2); push(3);
    chk("R4", "wptr after three", 32'(wptr_word), 96);
    @(negedge clk);
    vec_valid = 1'b1;
    repeat (5) @(negedge clk);
    chk("R5", "drain full stalls ready", 32'(vec_ready), 0);
    chk("R7", "wptr held", 32'(wptr_word), 96);
    vec_valid = 1'b0;
    ring(PTR_W'(32));
    chk("R7", "ready after doorbell", 32'(vec_ready), 1);
    push(4);
    mem_at("R4", 24, pat(4, 0));
    mem_at("R4", 31, pat(4, 7));
    chk("R4", "wptr wrap", 32'(wptr_word), 0);
    chk("R7", "no flag in drain", 32'(wptr_word[0]), 0);
    chk("R10", "irq after wrap", 32'(irq), 1);
  endtask

  task automatic t_overflow;
    cfg_write(1'b0, 11'h000);
    cfg_write(1'b0, 11'h493);                 // on, irq, size 4, ovf_en, wb
    push(5);
    chk("R4", "wptr first", 32'(wptr_word), 32);
    push(6);
    chk("R6", "flag set on full", 32'(wptr_word), 1);
    chk("R11", "writeback carries flag", 32'(wb_word), 1);
    chk("R10", "irq with equal ptrs", 32'(irq), 0);
    mem_at("R6", 8, pat(6, 0));
    push(7);
    mem_at("R6", 0, pat(7, 0));
    chk("R8", "flag sticky", 32'(wptr_word), 33);
    cfg_write(1'b0, 11'h593);
    chk("R8", "flag cleared", 32'(wptr_word), 32);
    chk("R2", "clear bit reads 0", 32'(ctrl_out), 32'h493);
  endtask

  task automatic t_silent;
    logic [PTR_W-1:0] wb_before;
    cfg_write(1'b0, 11'h000);
    wb_before = wb_word;
    cfg_write(1'b0, 11'h011);                 // on, size 4, no flag, no wb
    push(8); push(9);
    chk("R6", "silent overwrite no flag", 32'(wptr_word), 0);
    mem_at("R6", 8, pat(9, 0));
    chk("R11", "wb held when off", 32'(wb_word), 32'(wb_before));
  endtask

  task automatic t_disable;
    cfg_write(1'b0, 11'h000);
    cfg_write(1'b0, 11'h013);
    push(10);
    ring(PTR_W'(32));
    push(11);
    chk("R10", "irq before disable", 32'(irq), 1);
    cfg_write(1'b0, 11'h002);
    chk("R12", "ctrl after disable", 32'(ctrl_out), 32'h010);
    chk("R12", "wptr reset", 32'(wptr_word), 0);
    chk("R12", "rptr reset", 32'(rptr_out), 0);
    chk("R12", "irq off", 32'(irq), 0);
    @(negedge clk);
    vec_valid = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3", "ready low when off", 32'(vec_ready), 0);
    chk("R3", "no write when off", 32'(wptr_word), 0);
    vec_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ctrl_fields();
    t_basic();
    t_drain();
    t_overflow();
    t_silent();
    t_disable();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule